// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the two sleep states of a small microcontroller core. Software writes a power control byte. Setting the light-sleep bit stops the CPU clock while the peripherals keep running. Setting the deep-sleep bit stops both clocks and asks the oscillator to halt. While either state is held, the sequencer also overrides the external memory strobes and the two address/data ports, so the pins sit at the levels a board expects during sleep.

Light sleep ends as soon as any enabled interrupt is pending. Deep sleep ends only through an external interrupt pin, and only when four things are true: a separate wake-enable input is set, the pin is enabled, the pin is configured for level sensing, and the pin is low. The low level restarts the oscillator. The CPU clock comes back once a stabilisation counter has expired and the pin has returned high. A hardware reset in any state returns at once to the normal running state. The sequencer sends a one-cycle wake event to the interrupt logic whenever an interrupt ends a sleep state.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is in the running state at once, without waiting for a clock edge: `pmode`=00, `cpu_clk_en`=1, `per_clk_en`=1, `osc_stop`=0, `strobe_hold`=0, `strobe_level`=0, `p0_float`=0, `p2_addr_sel`=0 and `wake_evt`=0. The release of reset is synchronised to `clk`.
- R2: In the running state, a write (`ctl_wr`=1) takes effect at the next rising edge. Bit 0 of `ctl_wdata` selects light sleep and bit 1 selects deep sleep. `pmode` shows the result, with bit 0 = light sleep and bit 1 = deep sleep. All other data bits are ignored, and a write with bits 1:0 = 00 leaves the block running.
- R3: A write with both bits 1:0 set enters deep sleep (`pmode`=10).
- R4: In light sleep, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_stop`=0.
- R5: In light sleep, `irq_pend`=1 returns the block to the running state at the next edge. `wake_evt` is high for exactly that one cycle.
- R6: Writes made while the block is not running have no effect on `pmode`.
- R7: In deep sleep, `osc_stop`=1 and both clock enables are 0 until a wake-up begins. `irq_pend` does not end deep sleep.
- R8: A deep-sleep wake-up begins only when all of these hold: `wake_en`=1, and for some pin k, `ext_en[k]`=1, `ext_edge[k]`=0 (level-sensitive) and the active-low `ext_pin_n[k]`=0 after a two-stage synchroniser. When the wake-up begins, `osc_stop` drops to 0 while `pmode` stays 10.
- R9: After `osc_stop` drops, `cpu_clk_en` stays 0 while the waking pin is held low, and for at least STAB_CYCLES (default 16) cycles. The block then returns to the running state with a one-cycle `wake_evt`. If the pin is already high again, the gated interval is exactly STAB_CYCLES cycles.
- R10: In either sleep state, `strobe_hold`=1. `strobe_level` is 1 in light sleep and 0 in deep sleep.
- R11: `p0_float`=1 in either sleep state when `ext_program`=1. `p2_addr_sel`=1 only in light sleep with `ext_program`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ctl_wr | input | 1 | Write strobe for the power control byte |
| ctl_wdata | input | PCTL_W | Write data; bit 0 selects light sleep, bit 1 selects deep sleep |
| irq_pend | input | 1 | Any enabled interrupt pending |
| ext_pin_n | input | N_EXT | External interrupt pins, active low, asynchronous |
| ext_edge | input | N_EXT | Per-pin trigger mode: 1 = edge, 0 = level |
| ext_en | input | N_EXT | Per-pin interrupt enable |
| wake_en | input | 1 | Allows external pins to end deep sleep |
| ext_program | input | 1 | Core fetches from external program memory |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_stop | output | 1 | Request to halt the oscillator |
| pmode | output | 2 | Mode bits: bit 0 light sleep, bit 1 deep sleep |
| strobe_hold | output | 1 | Override the memory strobes |
| strobe_level | output | 1 | Level for the overridden strobes |
| p0_float | output | 1 | Put the low address/data port in high impedance |
| p2_addr_sel | output | 1 | Keep the high address port driving the address |
| wake_evt | output | 1 | One-cycle wake event to the interrupt logic |

## Verification
The bench first goes after the deep-sleep wake qualifiers one at a time: wake-enable clear, pin configured for edge sensing, and pin disabled. A design that skipped any one of these would restart the oscillator on a stray low level. It then holds the waking pin low well past the stabilisation time, and separately releases it early, counting the gated cycles exactly. A design that reopened the CPU clock on the counter alone, or that counted one cycle short, would show a count other than 16. Finally, the bench drops reset in the middle of both sleep states and samples before any clock edge. A design that cleared the mode bits only synchronously would still report sleep at that point.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_IDLE    = 2'd1,
    ST_PD_STOP = 2'd2,
    ST_PD_OSC  = 2'd3
  } lpm_state_e;

  localparam int unsigned PM_IDLE_BIT = 0;
  localparam int unsigned PM_PD_BIT   = 1;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic [N_EXT-1:0] ext_en,
  input  logic             wake_en,
  output logic             wake_low
);
  logic [N_EXT-1:0] qual_low;

  for (genvar k = 0; k < N_EXT; k++) begin : g_ch
    logic [SYNC_STAGES-1:0] sh_q;
    logic [SYNC_STAGES-1:0] sh_d;

    assign sh_d = {sh_q[SYNC_STAGES-2:0], ext_pin_n[k]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end

    assign qual_low[k] = ext_en[k] & ~ext_edge[k] & ~sh_q[SYNC_STAGES-1];
  end

  assign wake_low = wake_en & (|qual_low);
endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
  parameter int unsigned STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == LAST);
  assign cnt_en = !run || !done;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9
  stab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> !done || $past(cnt_q) == LAST - 1'b1);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned PCTL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [PCTL_W-1:0] ctl_wdata,
  input  logic              irq_pend,
  input  logic              wake_low,
  input  logic              wake_en,
  input  logic              stab_done,
  output lpm_state_e        state,
  output logic              wake_evt
);
  lpm_state_e state_q, state_d;
  logic       evt_q, evt_d;

  always_comb begin
    state_d = state_q;
    evt_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (ctl_wr) begin
          if (ctl_wdata[PM_PD_BIT])        state_d = ST_PD_STOP;
          else if (ctl_wdata[PM_IDLE_BIT]) state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (irq_pend) begin
          state_d = ST_RUN;
          evt_d   = 1'b1;
        end
      end
      ST_PD_STOP: begin
        if (wake_low) state_d = ST_PD_OSC;
      end
      ST_PD_OSC: begin
        if (stab_done && !wake_low) begin
          state_d = ST_RUN;
          evt_d   = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= evt_d;
    end
  end

  assign state    = state_q;
  assign wake_evt = evt_q;

  // R5
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !wake_evt);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !irq_pend) |=> state_q == ST_IDLE);

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD_STOP && !wake_en) |=> state_q == ST_PD_STOP);

  // R9
  stab_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD_OSC && !stab_done) |=> state_q != ST_RUN);
endmodule

// File: rtl/lpm_pin_ovr.sv
module lpm_pin_ovr
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       ext_program,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_stop,
  output logic [1:0] pmode,
  output logic       strobe_hold,
  output logic       strobe_level,
  output logic       p0_float,
  output logic       p2_addr_sel
);
  logic in_idle;
  logic in_pd;

  assign in_idle = (state == ST_IDLE);
  assign in_pd   = (state == ST_PD_STOP) || (state == ST_PD_OSC);

  always_comb begin
    pmode              = '0;
    pmode[PM_IDLE_BIT] = in_idle;
    pmode[PM_PD_BIT]   = in_pd;
  end

  assign cpu_clk_en   = (state == ST_RUN);
  assign per_clk_en   = !in_pd;
  assign osc_stop     = (state == ST_PD_STOP);
  assign strobe_hold  = in_idle || in_pd;
  assign strobe_level = in_idle;
  assign p0_float     = (in_idle || in_pd) && ext_program;
  assign p2_addr_sel  = in_idle && ext_program;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned PCTL_W      = 8,
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned STAB_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [PCTL_W-1:0] ctl_wdata,
  input  logic              irq_pend,
  input  logic [N_EXT-1:0]  ext_pin_n,
  input  logic [N_EXT-1:0]  ext_edge,
  input  logic [N_EXT-1:0]  ext_en,
  input  logic              wake_en,
  input  logic              ext_program,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_stop,
  output logic [1:0]        pmode,
  output logic              strobe_hold,
  output logic              strobe_level,
  output logic              p0_float,
  output logic              p2_addr_sel,
  output logic              wake_evt
);
  logic       rst_n_s;
  logic       wake_low;
  logic       stab_done;
  lpm_state_e state;

  lpm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  lpm_wake_detect #(.N_EXT(N_EXT), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ext_pin_n (ext_pin_n),
    .ext_edge  (ext_edge),
    .ext_en    (ext_en),
    .wake_en   (wake_en),
    .wake_low  (wake_low)
  );

  lpm_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (state == ST_PD_OSC),
    .done  (stab_done)
  );

  lpm_mode_fsm #(.PCTL_W(PCTL_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .irq_pend  (irq_pend),
    .wake_low  (wake_low),
    .wake_en   (wake_en),
    .stab_done (stab_done),
    .state     (state),
    .wake_evt  (wake_evt)
  );

  lpm_pin_ovr u_pins (
    .state        (state),
    .ext_program  (ext_program),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_stop     (osc_stop),
    .pmode        (pmode),
    .strobe_hold  (strobe_hold),
    .strobe_level (strobe_level),
    .p0_float     (p0_float),
    .p2_addr_sel  (p2_addr_sel)
  );

  // R7
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    osc_stop |-> (!cpu_clk_en && !per_clk_en));

  // R11
  p2_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    p2_addr_sel |-> (per_clk_en && !cpu_clk_en && ext_program));

  // R7
  pd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (osc_stop && irq_pend && !wake_en) |=> osc_stop);
endmodule

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
  localparam int unsigned STAB = 16;

  typedef struct packed {
    logic [7:0] wd;
    logic       xp;
    logic [1:0] mode;
    logic       cpu, per, osc, hold, lvl, p0f, p2a;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h01, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'h01, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h02, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h02, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'h03, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h83, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'hFC, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic       irq_pend;
  logic [1:0] ext_pin_n, ext_edge, ext_en;
  logic       wake_en, ext_program;
  logic       cpu_clk_en, per_clk_en, osc_stop, strobe_hold, strobe_level;
  logic       p0_float, p2_addr_sel, wake_evt;
  logic [1:0] pmode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .irq_pend(irq_pend), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
    .ext_en(ext_en), .wake_en(wake_en), .ext_program(ext_program),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_stop(osc_stop),
    .pmode(pmode), .strobe_hold(strobe_hold), .strobe_level(strobe_level),
    .p0_float(p0_float), .p2_addr_sel(p2_addr_sel), .wake_evt(wake_evt)
  );

  function automatic logic [9:0] outs();
    return {pmode, cpu_clk_en, per_clk_en, osc_stop, strobe_hold,
            strobe_level, p0_float, p2_addr_sel, wake_evt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; irq_pend = 1'b0;
    ext_pin_n = 2'b11; ext_edge = 2'b00; ext_en = 2'b00;
    wake_en = 1'b0; ext_program = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk("R1 hold", outs(), 10'b00_1100_0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 released", outs(), 10'b00_1100_0000);

    // Vector walk: R2 R3 R4 R7 R10 R11
    for (int i = 0; i < NV; i++) begin
      do_reset();
      ext_program = VECS[i].xp;
      wr(VECS[i].wd);
      chk($sformatf("R2/R3/R4/R7/R10/R11 vec%0d", i), outs(),
          {VECS[i].mode, VECS[i].cpu, VECS[i].per, VECS[i].osc, VECS[i].hold,
           VECS[i].lvl, VECS[i].p0f, VECS[i].p2a, 1'b0});
    end
    ext_program = 1'b0;

    // R6 and R5: light sleep ignores writes, leaves on interrupt
    do_reset();
    wr(8'h01);
    wr(8'h02);
    repeat (3) @(negedge clk);
    chk("R6 write in idle", pmode, 2'b01);
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    chk("R5 idle exit", {pmode, cpu_clk_en, wake_evt}, 4'b0011);
    @(negedge clk);
    chk("R5 pulse width", wake_evt, 1'b0);

    // R7: interrupt does not end deep sleep; R6 write ignored
    do_reset();
    wr(8'h02);
    irq_pend = 1'b1;
    wr(8'h01);
    repeat (5) @(negedge clk);
    irq_pend = 1'b0;
    chk("R7 irq in pd", {pmode, osc_stop, cpu_clk_en, per_clk_en}, 5'b10100);
    chk("R6 write in pd", pmode, 2'b10);

    // R8: qualifiers one by one
    ext_en = 2'b01; ext_edge = 2'b00; wake_en = 1'b0; ext_pin_n = 2'b10;
    repeat (10) @(negedge clk);
    chk("R8 wake_en off", {pmode, osc_stop}, 3'b101);
    wake_en = 1'b1; ext_edge = 2'b01;
    repeat (10) @(negedge clk);
    chk("R8 edge mode", {pmode, osc_stop}, 3'b101);
    ext_edge = 2'b00; ext_en = 2'b10;
    repeat (10) @(negedge clk);
    chk("R8 pin disabled", {pmode, osc_stop}, 3'b101);
    ext_en = 2'b01;
    n = 0;
    while (osc_stop && n < 8) begin @(negedge clk); n++; end
    chk("R8 osc restart", {pmode, osc_stop}, 3'b100);
    // R9: pin held low long past stabilisation
    repeat (40) @(negedge clk);
    chk("R9 held low", {pmode, cpu_clk_en, osc_stop}, 4'b1000);
    ext_pin_n = 2'b11;
    n = 0;
    while (!cpu_clk_en && n < 8) begin @(negedge clk); n++; end
    chk("R9 exit after high", {pmode, cpu_clk_en, wake_evt}, 4'b0011);

    // R9: exact stabilisation interval on pin 1
    do_reset();
    wake_en = 1'b1; ext_en = 2'b10; ext_edge = 2'b00;
    wr(8'h02);
    ext_pin_n = 2'b01;
    n = 0;
    while (osc_stop && n < 8) begin @(negedge clk); n++; end
    ext_pin_n = 2'b11;
    n = 0;
    while (!cpu_clk_en && n < 100) begin n++; @(negedge clk); end
    chk("R9 stab count", n, STAB);
    chk("R9 wake event", wake_evt, 1'b1);

    // R1: asynchronous clear in deep sleep and light sleep
    do_reset();
    wr(8'h02);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async pd", outs(), 10'b00_1100_0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h01);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async idle", outs(), 10'b00_1100_0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule